// File: doc/BRIEF.md
# Peer connection message sequencer

This block decodes the one-way setup stream that a shared-memory coordination server sends to each client. The stream arrives one byte at a time. Every eight bytes form one signed 64-bit message, least significant byte first, and a sideband flag tells whether a descriptor handle came with the message. The block walks through the ordered setup phases:

- a protocol version check;
- capture of the client's own ID;
- the shared-memory announcement;
- connect notifications for peers that are already present;
- repetitions of the own ID, which set up the receive vectors.

After setup it keeps following peers as they connect and disconnect.

The per-peer state is held in a table: a connected flag and a count of outgoing vectors. A combinational query port reads any entry of the table. Any protocol violation closes the connection. From then on the block accepts no further bytes until reset. Handle bookkeeping and the host socket belong to the surrounding logic.

The byte input is a valid/ready stream. A byte transfers on a rising clock edge where `in_valid` and `in_ready` are both high. The sender holds `in_data` and `in_handle` steady while `in_valid` is high and `in_ready` is low. Gaps with `in_valid` low may appear anywhere, including inside a message. `in_ready` is high whenever the connection is open and low once it is closed. Closing is the only source of back-pressure.

Top module: `peer_msg_seq`

## Requirements
- R1: A message is eight accepted bytes. The first byte accepted is bits 7:0 and the eighth is bits 63:56. The handle flag is taken with the eighth byte. Idle cycles between bytes do not change the assembled value.
- R2: A first message that is not 0 closes the connection. Once closed, `closed` stays high and `in_ready` stays low until reset.
- R3: The second message is the own ID and appears on `own_id`. A value below 0 or above 65535 closes the connection.
- R4: The third message must equal -1 and carry a handle. Otherwise the connection closes.
- R5: During setup, a peer ID (other than the own ID) that carries a handle marks that peer connected and raises its vector count by one. The count stops at NUM_VEC, so surplus handles are discarded.
- R6: Each own-ID repetition that carries a handle raises `rx_vec_count` by one, up to NUM_VEC.
- R7: `setup_done` rises on the first message that is not a handle-carrying own-ID repetition, provided at least one such repetition came before it. That message is then handled as a runtime message.
- R8: At runtime, a peer ID with a handle connects one more vector (saturating as in R5). A peer ID without a handle clears that peer's connected flag and sets its count to 0.
- R9: The connection closes on any of these: a peer ID equal to the own ID, a peer ID outside 0..65535, or a peer message without a handle before the first own-ID repetition.
- R10: A valid peer ID at or above NUM_PEERS is accepted without error and changes no table entry. `q_connected` and `q_vec_count` show the entry selected by `q_peer` in the same cycle.
- R11: After reset: `in_ready`=1, `own_id`=0, `setup_done`=0, `closed`=0, `rx_vec_count`=0, and every table entry is disconnected with count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_valid | input | 1 | byte stream valid |
| in_ready | output | 1 | byte stream ready (low once closed) |
| in_data | input | 8 | stream byte |
| in_handle | input | 1 | handle accompanies message (taken with the last byte) |
| own_id | output | 16 | captured own ID |
| setup_done | output | 1 | setup phase complete |
| closed | output | 1 | protocol error, connection closed |
| rx_vec_count | output | $clog2(NUM_VEC+1) | connected receive vectors |
| q_peer | input | $clog2(NUM_PEERS) | table query index |
| q_connected | output | 1 | queried peer connected |
| q_vec_count | output | $clog2(NUM_VEC+1) | queried peer vector count |

## Verification
The bench sends an own ID of 258. If the byte order were reversed, the assembled value would be out of range and the connection would close instead. It also sends one message with idle gaps between its bytes, which catches a byte counter that moves on gaps. It sends more handles than NUM_VEC, both for a peer and for the own ID. A count that wraps instead of saturating would show a small value in either case. A runtime disconnect is checked to clear both the flag and the count, and that same message must be the one that raises `setup_done`. Each error path is driven separately, and each must leave `in_ready` low. A peer ID beyond the table size must cause no error and no change to any entry.

// File: rtl/peer_seq_pkg.sv
package peer_seq_pkg;

  typedef enum logic [2:0] {
    PH_VER,
    PH_ID,
    PH_SHM,
    PH_PEERS,
    PH_OWN,
    PH_RUN,
    PH_CLOSED
  } phase_t;

  typedef struct packed {
    logic [63:0] value;
    logic        handle;
  } msg_t;

endpackage

// File: rtl/msg_asm.sv
module msg_asm
  import peer_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept_en,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_handle,
  output logic       msg_valid,
  output msg_t       msg
);

  localparam int BYTES = 8;
  localparam int BW    = $clog2(BYTES);

  logic [BW-1:0] idx;
  logic [55:0]   low_bytes;
  logic          fire;

  assign in_ready = accept_en;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      low_bytes <= '0;
      msg_valid <= 1'b0;
      msg       <= '0;
    end else begin
      msg_valid <= 1'b0;
      if (fire) begin
        if (idx == BW'(BYTES - 1)) begin
          msg.value  <= {in_data, low_bytes};
          msg.handle <= in_handle;
          msg_valid  <= 1'b1;
          idx        <= '0;
        end else begin
          low_bytes[{idx, 3'b000} +: 8] <= in_data;
          idx                           <= idx + 1'b1;
        end
      end
    end
  end

  // A message needs eight transfers, so two back-to-back pulses are impossible.
  assert_msg_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> !msg_valid);

endmodule

// File: rtl/peer_tbl.sv
module peer_tbl #(
  parameter int NUM_PEERS = 16,
  parameter int NUM_VEC   = 4,
  localparam int PW = $clog2(NUM_PEERS),
  localparam int VW = $clog2(NUM_VEC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conn_en,
  input  logic          disc_en,
  input  logic [PW-1:0] idx,
  input  logic [PW-1:0] q_idx,
  output logic          q_conn,
  output logic [VW-1:0] q_cnt
);

  logic          conn_q [NUM_PEERS];
  logic [VW-1:0] cnt_q  [NUM_PEERS];

  for (genvar g = 0; g < NUM_PEERS; g++) begin : g_entry
    logic hit;
    assign hit = (idx == PW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        conn_q[g] <= 1'b0;
        cnt_q[g]  <= '0;
      end else if (hit && disc_en) begin
        conn_q[g] <= 1'b0;
        cnt_q[g]  <= '0;
      end else if (hit && conn_en) begin
        conn_q[g] <= 1'b1;
        if (cnt_q[g] != VW'(NUM_VEC)) cnt_q[g] <= cnt_q[g] + 1'b1;
      end
    end

    assert_idle_entry_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !conn_q[g] |-> (cnt_q[g] == '0));
    assert_vec_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[g] <= VW'(NUM_VEC));
  end

  always_comb begin
    q_conn = 1'b0;
    q_cnt  = '0;
    for (int i = 0; i < NUM_PEERS; i++) begin
      if (q_idx == PW'(i)) begin
        q_conn = conn_q[i];
        q_cnt  = cnt_q[i];
      end
    end
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import peer_seq_pkg::*;
#(
  parameter int NUM_PEERS = 16,
  parameter int NUM_VEC   = 4,
  localparam int PW = $clog2(NUM_PEERS),
  localparam int VW = $clog2(NUM_VEC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msg_valid,
  input  msg_t          msg,
  output logic [15:0]   own_id,
  output logic          setup_done,
  output logic          closed,
  output logic [VW-1:0] rx_cnt,
  output logic          tbl_conn,
  output logic          tbl_disc,
  output logic [PW-1:0] tbl_idx
);

  phase_t phase, nxt_phase;

  logic signed [63:0] sval;
  logic id_ok, is_own, tracked;
  logic err, do_conn, do_disc, rx_inc, set_done, ld_id;

  assign sval    = msg.value;
  assign id_ok   = (sval >= 64'sd0) && (sval <= 64'sd65535);
  assign is_own  = (msg.value == {48'd0, own_id});
  assign tracked = (msg.value < 64'(NUM_PEERS));
  assign tbl_idx = msg.value[PW-1:0];

  always_comb begin
    nxt_phase = phase;
    err       = 1'b0;
    do_conn   = 1'b0;
    do_disc   = 1'b0;
    rx_inc    = 1'b0;
    set_done  = 1'b0;
    ld_id     = 1'b0;
    if (msg_valid) begin
      unique case (phase)
        PH_VER: begin
          if (msg.value != 64'd0) err = 1'b1;
          else nxt_phase = PH_ID;
        end
        PH_ID: begin
          if (!id_ok) err = 1'b1;
          else begin
            ld_id     = 1'b1;
            nxt_phase = PH_SHM;
          end
        end
        PH_SHM: begin
          if (sval != -64'sd1 || !msg.handle) err = 1'b1;
          else nxt_phase = PH_PEERS;
        end
        PH_PEERS: begin
          if (!msg.handle || !id_ok) err = 1'b1;
          else if (is_own) begin
            rx_inc    = 1'b1;
            nxt_phase = PH_OWN;
          end else begin
            do_conn = tracked;
          end
        end
        PH_OWN, PH_RUN: begin
          if (phase == PH_OWN && is_own && msg.handle) begin
            rx_inc = 1'b1;
          end else begin
            set_done  = (phase == PH_OWN);
            nxt_phase = PH_RUN;
            if (!id_ok || is_own) err = 1'b1;
            else if (msg.handle) do_conn = tracked;
            else do_disc = tracked;
          end
        end
        default: ;
      endcase
      if (err) nxt_phase = PH_CLOSED;
    end
  end

  assign tbl_conn = do_conn && !err;
  assign tbl_disc = do_disc && !err;
  assign closed   = (phase == PH_CLOSED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_VER;
      own_id     <= '0;
      setup_done <= 1'b0;
      rx_cnt     <= '0;
    end else begin
      phase <= nxt_phase;
      if (ld_id) own_id <= msg.value[15:0];
      if (set_done && !err) setup_done <= 1'b1;
      if (rx_inc && rx_cnt != VW'(NUM_VEC)) rx_cnt <= rx_cnt + 1'b1;
    end
  end

  assert_close_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    closed |=> closed);
  assert_done_needs_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |-> (rx_cnt != '0));
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |=> setup_done);
  assert_rx_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= VW'(NUM_VEC));
  assert_no_table_write_when_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    closed |-> !(tbl_conn || tbl_disc));

endmodule

// File: rtl/peer_msg_seq.sv
module peer_msg_seq
  import peer_seq_pkg::*;
#(
  parameter int NUM_PEERS = 16,
  parameter int NUM_VEC   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [7:0]                   in_data,
  input  logic                         in_handle,
  output logic [15:0]                  own_id,
  output logic                         setup_done,
  output logic                         closed,
  output logic [$clog2(NUM_VEC+1)-1:0] rx_vec_count,
  input  logic [$clog2(NUM_PEERS)-1:0] q_peer,
  output logic                         q_connected,
  output logic [$clog2(NUM_VEC+1)-1:0] q_vec_count
);

  localparam int PW = $clog2(NUM_PEERS);

  logic          msg_valid;
  msg_t          msg;
  logic          tbl_conn, tbl_disc;
  logic [PW-1:0] tbl_idx;

  msg_asm u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_en (!closed),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_handle (in_handle),
    .msg_valid (msg_valid),
    .msg       (msg)
  );

  seq_ctrl #(.NUM_PEERS(NUM_PEERS), .NUM_VEC(NUM_VEC)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .msg        (msg),
    .own_id     (own_id),
    .setup_done (setup_done),
    .closed     (closed),
    .rx_cnt     (rx_vec_count),
    .tbl_conn   (tbl_conn),
    .tbl_disc   (tbl_disc),
    .tbl_idx    (tbl_idx)
  );

  peer_tbl #(.NUM_PEERS(NUM_PEERS), .NUM_VEC(NUM_VEC)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .conn_en (tbl_conn),
    .disc_en (tbl_disc),
    .idx     (tbl_idx),
    .q_idx   (q_peer),
    .q_conn  (q_connected),
    .q_cnt   (q_vec_count)
  );

  assert_closed_blocks_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    closed |-> !in_ready);

endmodule

// File: tb/test_peer_msg_seq.sv
module test_peer_msg_seq;

  localparam int NP = 16;
  localparam int NV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_handle = 1'b0;
  logic [15:0] own_id;
  logic       setup_done, closed;
  logic [$clog2(NV+1)-1:0] rx_vec_count, q_vec_count;
  logic [$clog2(NP)-1:0]   q_peer = '0;
  logic       q_connected;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  peer_msg_seq #(.NUM_PEERS(NP), .NUM_VEC(NV)) i_peer_msg_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_handle(in_handle), .own_id(own_id),
    .setup_done(setup_done), .closed(closed), .rx_vec_count(rx_vec_count),
    .q_peer(q_peer), .q_connected(q_connected), .q_vec_count(q_vec_count)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_msg(input logic [63:0] v, input logic h, input int gap = 0);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      if (!in_ready) begin
        in_valid = 1'b0;
        return;
      end
      in_valid  = 1'b1;
      in_data   = v[b*8 +: 8];
      in_handle = h;
      @(posedge clk);
      if (gap > 0 && b < 7) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 8'hA5;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic peer(input int p, input logic [63:0] ec, input logic [63:0] ecnt, input string req);
    q_peer = p[$clog2(NP)-1:0];
    #1;
    chk({req, " conn"}, q_connected, ec);
    chk({req, " cnt"}, q_vec_count, ecnt);
  endtask

  task automatic preamble(input logic [63:0] id);
    send_msg(64'd0, 1'b0);
    send_msg(id, 1'b0);
    send_msg(-64'sd1, 1'b1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 ready", in_ready, 1);
    chk("R11 own_id", own_id, 0);
    chk("R11 done", setup_done, 0);
    chk("R11 closed", closed, 0);
    chk("R11 rx", rx_vec_count, 0);
    for (int p = 0; p < NP; p++) peer(p, 0, 0, "R11 table");
  endtask

  task automatic t_bad_version();
    do_reset();
    send_msg(64'd1, 1'b0);
    chk("R2 closed", closed, 1);
    chk("R2 ready", in_ready, 0);
    repeat (5) @(negedge clk);
    chk("R2 still closed", in_ready, 0);
  endtask

  task automatic t_full_flow();
    do_reset();
    send_msg(64'd0, 1'b0);
    send_msg(64'd258, 1'b0, 2);
    chk("R1 R3 own_id byte order", own_id, 258);
    chk("R1 open", closed, 0);
    send_msg(-64'sd1, 1'b1);
    chk("R4 shm ok", closed, 0);
    for (int i = 0; i < 3; i++) send_msg(64'd2, 1'b1);
    for (int i = 0; i < 6; i++) send_msg(64'd3, 1'b1);
    peer(2, 1, 3, "R5 peer2");
    peer(3, 1, NV, "R5 peer3 saturate");
    send_msg(64'd20, 1'b1);
    chk("R10 far peer no error", closed, 0);
    for (int p = 0; p < NP; p++) if (p != 2 && p != 3) peer(p, 0, 0, "R10 untouched");
    send_msg(64'd258, 1'b1);
    send_msg(64'd258, 1'b1);
    chk("R6 rx", rx_vec_count, 2);
    chk("R7 not yet done", setup_done, 0);
    send_msg(64'd3, 1'b0);
    chk("R7 done", setup_done, 1);
    peer(3, 0, 0, "R8 disconnect");
    peer(2, 1, 3, "R8 other kept");
    send_msg(64'd7, 1'b1);
    peer(7, 1, 1, "R8 runtime connect");
    send_msg(64'd258, 1'b1);
    chk("R9 own as peer", closed, 1);
    chk("R9 ready low", in_ready, 0);
  endtask

  task automatic t_rx_saturate();
    do_reset();
    preamble(64'd4);
    for (int i = 0; i < 6; i++) send_msg(64'd4, 1'b1);
    chk("R6 saturate", rx_vec_count, NV);
    send_msg(64'd1, 1'b1);
    chk("R7 done via connect", setup_done, 1);
    peer(1, 1, 1, "R7 message processed");
  endtask

  task automatic t_errors();
    do_reset();
    send_msg(64'd0, 1'b0);
    send_msg(64'd70000, 1'b0);
    chk("R3 id too large", closed, 1);
    do_reset();
    send_msg(64'd0, 1'b0);
    send_msg(-64'sd5, 1'b0);
    chk("R3 id negative", closed, 1);
    do_reset();
    send_msg(64'd0, 1'b0);
    send_msg(64'd1, 1'b0);
    send_msg(-64'sd1, 1'b0);
    chk("R4 no handle", closed, 1);
    do_reset();
    send_msg(64'd0, 1'b0);
    send_msg(64'd1, 1'b0);
    send_msg(64'd0, 1'b1);
    chk("R4 wrong value", closed, 1);
    do_reset();
    preamble(64'd1);
    send_msg(64'd2, 1'b0);
    chk("R9 setup peer without handle", closed, 1);
    do_reset();
    preamble(64'd1);
    send_msg(64'd1, 1'b1);
    send_msg(64'd65536, 1'b1);
    chk("R9 peer out of range", closed, 1);
    chk("R9 done not set on error", setup_done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bad_version();
    t_full_flow();
    t_rx_saturate();
    t_errors();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule